// File: doc/BRIEF.md
# YUV to RGB colour space converter

This block turns one pixel of 8-bit luma and chroma samples (Y, U, V) into 8-bit red, green and blue components. A pixel is presented with `in_valid`; its result appears on the output side with `out_valid` a fixed three clock cycles later. A new pixel can be accepted on every cycle.

The luma sample first has a signed offset added and is clamped to 0..255. The clamped value is then scaled by a shared unsigned luma gain. Each channel adds two chroma terms, formed from U-128 and V-128 and each weighted by that channel's own signed coefficient. The sum drops its eight fraction bits with round-half-up and is clamped to 0..255.

Eight coefficient registers, each 16 bits wide, set the conversion. Each field sits right-justified in its register, and any register bits above the field are discarded. Every pixel takes a snapshot of the coefficients when it is accepted, so a pixel already in the pipeline is never affected by a later write.

Top module: `csc_yuv_rgb`

## Requirements
- R1: While `rst_n` is low, and after its release, `out_valid` and all three colour outputs are 0. The coefficients reset to offset 0 and luma gain 1.0 with all chroma weights 0, so each output channel then equals Y.
- R2: With `coef_we` high, `coef_wdata` goes to the register chosen by `coef_sel`. The selections are: 0 luma offset in bits [7:0]; 1 luma gain in bits [9:0]; 2 red U weight, 3 red V weight, 6 blue U weight and 7 blue V weight, each in bits [10:0]; 4 green U weight and 5 green V weight, in bits [9:0]. Bits above each field are ignored.
- R3: The luma offset is 8-bit two's complement. Y plus the offset is clamped to 0..255 before it is scaled.
- R4: The luma gain is unsigned with 8 fraction bits. The red and blue weights are two's complement with 2 integer and 8 fraction bits. The green weights are two's complement with 1 integer and 8 fraction bits. U and V are used as U-128 and V-128.
- R5: Each channel is gain×clamped luma + Uweight×(U-128) + Vweight×(V-128). To form the output, 128 is added and the sum is shifted right arithmetically by 8, which rounds halves upward.
- R6: A channel result below 0 gives 0, and one above 255 gives 255.
- R7: `out_valid` is high exactly three cycles after each cycle with `in_valid` high, and back-to-back pixels come out back to back.
- R8: The colour outputs keep their last value while `out_valid` is low.
- R9: A coefficient write in the same cycle as an accepted pixel does not affect that pixel, but it does affect the next accepted pixel. A pixel already in flight is not affected by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient register select |
| coef_wdata | input | 16 | Coefficient write value |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
The hardest situation to reach is a coefficient write that lands in the same cycle a pixel is accepted, with a second pixel following directly behind. The stimulus sets `coef_we` and `in_valid` on the same edge and then sends a second pixel on the next cycle. It then checks that the first result uses the old weight and the second uses the new one. Both inner and outer clamping are forced with extreme coefficient sets, and one of those sets carries non-zero junk in the upper register bits.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;
  localparam int REG_W  = 16;
  localparam int YOF_W  = PIX_W;          // signed, no fraction
  localparam int KY_W   = FRAC_W + 2;     // unsigned 2.8
  localparam int KRB_W  = FRAC_W + 3;     // signed 2.8
  localparam int KG_W   = FRAC_W + 2;     // signed 1.8
  localparam int CHR_W  = PIX_W + 1;      // re-centred chroma
  localparam int YS_W   = PIX_W + 2;      // luma plus offset
  localparam int LP_W   = PIX_W + KY_W;   // luma product
  localparam int PR_W   = KRB_W + CHR_W;  // chroma product
  localparam int ACC_W  = LP_W + 4;       // channel accumulator
  localparam int N_CH   = 3;

  typedef enum logic [2:0] {
    SEL_YOF = 3'd0, SEL_KY = 3'd1, SEL_KRU = 3'd2, SEL_KRV = 3'd3,
    SEL_KGU = 3'd4, SEL_KGV = 3'd5, SEL_KBU = 3'd6, SEL_KBV = 3'd7
  } coef_sel_e;

  typedef struct packed {
    logic [YOF_W-1:0] yof;
    logic [KY_W-1:0]  ky;
    logic [KRB_W-1:0] kru;
    logic [KRB_W-1:0] krv;
    logic [KG_W-1:0]  kgu;
    logic [KG_W-1:0]  kgv;
    logic [KRB_W-1:0] kbu;
    logic [KRB_W-1:0] kbv;
  } coef_t;
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output coef_t            cfg
);
  coef_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (coef_sel_e'(sel))
      SEL_YOF: cfg_d.yof = wdata[YOF_W-1:0];
      SEL_KY:  cfg_d.ky  = wdata[KY_W-1:0];
      SEL_KRU: cfg_d.kru = wdata[KRB_W-1:0];
      SEL_KRV: cfg_d.krv = wdata[KRB_W-1:0];
      SEL_KGU: cfg_d.kgu = wdata[KG_W-1:0];
      SEL_KGV: cfg_d.kgv = wdata[KG_W-1:0];
      SEL_KBU: cfg_d.kbu = wdata[KRB_W-1:0];
      SEL_KBV: cfg_d.kbv = wdata[KRB_W-1:0];
      default: cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_q.ky  <= KY_W'(1 << FRAC_W);
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/csc_front.sv
module csc_front
  import csc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [PIX_W-1:0]        y,
  input  logic [PIX_W-1:0]        u,
  input  logic [PIX_W-1:0]        v,
  input  coef_t                   cfg_in,
  output logic [PIX_W-1:0]        ys,
  output logic signed [CHR_W-1:0] uc,
  output logic signed [CHR_W-1:0] vc,
  output coef_t                   cfg_out
);
  logic [YS_W-1:0]  ysum;
  logic [PIX_W-1:0] ys_d;
  logic [CHR_W-1:0] uc_d, vc_d;

  always_comb begin
    ysum = YS_W'(y) + {{(YS_W-YOF_W){cfg_in.yof[YOF_W-1]}}, cfg_in.yof};
    if (ysum[YS_W-1])      ys_d = '0;
    else if (ysum[PIX_W])  ys_d = '1;
    else                   ys_d = ysum[PIX_W-1:0];
    uc_d = CHR_W'(u) - CHR_W'(1 << (PIX_W-1));
    vc_d = CHR_W'(v) - CHR_W'(1 << (PIX_W-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ys      <= '0;
      uc      <= '0;
      vc      <= '0;
      cfg_out <= '0;
    end else if (en) begin
      ys      <= ys_d;
      uc      <= $signed(uc_d);
      vc      <= $signed(vc_d);
      cfg_out <= cfg_in;
    end
  end
endmodule

// File: rtl/csc_channel.sv
module csc_channel
  import csc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_acc,
  input  logic                    en_out,
  input  logic [LP_W-1:0]         luma,
  input  logic signed [KRB_W-1:0] ku,
  input  logic signed [KRB_W-1:0] kv,
  input  logic signed [CHR_W-1:0] uc,
  input  logic signed [CHR_W-1:0] vc,
  output logic [PIX_W-1:0]        pix
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W-1);

  logic signed [PR_W-1:0]  pu, pv;
  logic [ACC_W-1:0]        acc_d, acc_q, rnd, shf;
  logic [PIX_W-1:0]        pix_d;

  always_comb begin
    pu    = PR_W'(ku) * PR_W'(uc);
    pv    = PR_W'(kv) * PR_W'(vc);
    acc_d = {{(ACC_W-LP_W){1'b0}}, luma}
          + {{(ACC_W-PR_W){pu[PR_W-1]}}, pu}
          + {{(ACC_W-PR_W){pv[PR_W-1]}}, pv};
  end

  always_comb begin
    rnd = acc_q + HALF;
    shf = ACC_W'($signed(rnd) >>> FRAC_W);
    if (shf[ACC_W-1])                pix_d = '0;
    else if (|shf[ACC_W-2:PIX_W])    pix_d = '1;
    else                             pix_d = shf[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (en_acc) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pix <= '0;
    else if (en_out) pix <= pix_d;
  end
endmodule

// File: rtl/csc_yuv_rgb.sv
module csc_yuv_rgb
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_we,
  input  logic [2:0]       coef_sel,
  input  logic [REG_W-1:0] coef_wdata,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_u,
  input  logic [PIX_W-1:0] in_v,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);
  localparam int N_STG = 3;

  coef_t                   cfg_live, cfg_s1;
  logic [PIX_W-1:0]        s1_y;
  logic signed [CHR_W-1:0] s1_u, s1_v;
  logic [LP_W-1:0]         luma;
  logic signed [KRB_W-1:0] ku [N_CH];
  logic signed [KRB_W-1:0] kv [N_CH];
  logic [PIX_W-1:0]        pix [N_CH];
  logic [N_STG-1:0]        vld_q, vld_d;

  csc_coef_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .sel(coef_sel),
    .wdata(coef_wdata), .cfg(cfg_live)
  );

  csc_front u_front (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .y(in_y), .u(in_u), .v(in_v), .cfg_in(cfg_live),
    .ys(s1_y), .uc(s1_u), .vc(s1_v), .cfg_out(cfg_s1)
  );

  assign luma = LP_W'(s1_y) * LP_W'(cfg_s1.ky);

  always_comb begin
    ku[0] = $signed(cfg_s1.kru);
    kv[0] = $signed(cfg_s1.krv);
    ku[1] = $signed({{(KRB_W-KG_W){cfg_s1.kgu[KG_W-1]}}, cfg_s1.kgu});
    kv[1] = $signed({{(KRB_W-KG_W){cfg_s1.kgv[KG_W-1]}}, cfg_s1.kgv});
    ku[2] = $signed(cfg_s1.kbu);
    kv[2] = $signed(cfg_s1.kbv);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    csc_channel u_ch (
      .clk(clk), .rst_n(rst_n), .en_acc(vld_q[0]), .en_out(vld_q[1]),
      .luma(luma), .ku(ku[c]), .kv(kv[c]), .uc(s1_u), .vc(s1_v),
      .pix(pix[c])
    );
  end

  always_comb vld_d = {vld_q[N_STG-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q[N_STG-1];
  assign out_r     = pix[0];
  assign out_g     = pix[1];
  assign out_b     = pix[2];
endmodule

// File: rtl/csc_yuv_rgb_chk.sv
module csc_yuv_rgb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (!out_valid && out_r == 8'd0 && out_g == 8'd0 && out_b == 8'd0));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R7
  known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_r, out_g, out_b}));
endmodule

bind csc_yuv_rgb csc_yuv_rgb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/sim_csc_yuv_rgb.sv
module sim_csc_yuv_rgb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        coef_we;
  logic [2:0]  coef_sel;
  logic [15:0] coef_wdata;
  logic        in_valid;
  logic [7:0]  in_y, in_u, in_v;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  csc_yuv_rgb u0 (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .in_valid(in_valid), .in_y(in_y), .in_u(in_u),
    .in_v(in_v), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // fields: yof, ky, kru, krv, kgu, kgv, kbu, kbv, y, u, v
  localparam int NV = 8;
  localparam logic [175:0] VEC [NV] = '{
    {16'h00F0,16'h012A,16'h0000,16'h0199,16'h039C,16'h0330,16'h0204,16'h0000,16'd16, 16'd128,16'd128},
    {16'h00F0,16'h012A,16'h0000,16'h0199,16'h039C,16'h0330,16'h0204,16'h0000,16'd235,16'd128,16'd128},
    {16'h00F0,16'h012A,16'h0000,16'h0199,16'h039C,16'h0330,16'h0204,16'h0000,16'd81, 16'd90, 16'd240},
    {16'h00F0,16'h012A,16'h0000,16'h0199,16'h039C,16'h0330,16'h0204,16'h0000,16'd255,16'd255,16'd255},
    {16'h00F0,16'h012A,16'h0000,16'h0199,16'h039C,16'h0330,16'h0204,16'h0000,16'd0,  16'd0,  16'd0},
    {16'h007F,16'h03FF,16'h0400,16'h03FF,16'h0200,16'h01FF,16'h03FF,16'h0400,16'd200,16'd0,  16'd255},
    {16'h007F,16'h03FF,16'h0400,16'h03FF,16'h0200,16'h01FF,16'h03FF,16'h0400,16'd30, 16'd255,16'd0},
    {16'hFF80,16'hFD00,16'hF880,16'hF800,16'hFC40,16'hFC00,16'hF800,16'hF880,16'd200,16'd200,16'd60}
  };

  function automatic int clamp8(int x);
    return (x < 0) ? 0 : (x > 255) ? 255 : x;
  endfunction

  // Reference: R3 inner clamp, R4 formats, R5 rounding, R6 outer clamp
  function automatic logic [23:0] model(logic [127:0] c, int y, int u, int v);
    int yo, ky, kru, krv, kgu, kgv, kbu, kbv, ys, uc, vc, r, g, b;
    yo  = $signed(c[127-:16][7:0]);
    ky  = int'(c[111-:16][9:0]);
    kru = $signed(c[95-:16][10:0]);
    krv = $signed(c[79-:16][10:0]);
    kgu = $signed(c[63-:16][9:0]);
    kgv = $signed(c[47-:16][9:0]);
    kbu = $signed(c[31-:16][10:0]);
    kbv = $signed(c[15-:16][10:0]);
    ys  = clamp8(y + yo);
    uc  = u - 128;
    vc  = v - 128;
    r = clamp8((ys*ky + kru*uc + krv*vc + 128) >>> 8);
    g = clamp8((ys*ky + kgu*uc + kgv*vc + 128) >>> 8);
    b = clamp8((ys*ky + kbu*uc + kbv*vc + 128) >>> 8);
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic check(string req, logic [24:0] act, logic [24:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [15:0] d);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 3'(sel); coef_wdata = d;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic pix_chk(string req, int y, int u, int v, logic [23:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req, {out_valid, out_r, out_g, out_b}, {1'b1, exp});
  endtask

  initial begin
    logic [127:0] cs;
    logic [23:0]  e0, e1;
    rst_n = 1'b0; coef_we = 1'b0; coef_sel = '0; coef_wdata = '0;
    in_valid = 1'b0; in_y = '0; in_u = '0; in_v = '0;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1", {out_valid, out_r, out_g, out_b}, 25'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_r, out_g, out_b}, 25'd0);
    // R1 reset coefficients pass Y through on every channel
    pix_chk("R1", 77, 3, 250, {8'd77, 8'd77, 8'd77});

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 8; k++) wr(k, VEC[i][175-16*k -: 16]);
      cs = VEC[i][175:48];
      pix_chk($sformatf("R5 vec%0d", i), int'(VEC[i][47:32]), int'(VEC[i][31:16]),
              int'(VEC[i][15:0]), model(cs, int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0])));
    end

    // R5 round-half-up: gain 1.5, Y=1 -> 1.5 -> 2 ; Y=3 -> 4.5 -> 5
    for (int k = 0; k < 8; k++) wr(k, 16'h0000);
    wr(1, 16'h0180);
    pix_chk("R5", 1, 128, 128, {8'd2, 8'd2, 8'd2});
    pix_chk("R5", 3, 128, 128, {8'd5, 8'd5, 8'd5});
    // R4 chroma re-centring: red U weight 0.5, U=129 -> 0.5 -> 1; U=127 -> -0.5 -> 0
    wr(1, 16'h0000);
    wr(2, 16'h0080);
    pix_chk("R4", 0, 129, 0, {8'd1, 8'd0, 8'd0});
    pix_chk("R4", 0, 127, 0, {8'd0, 8'd0, 8'd0});
    // R3 negative offset clamps luma to 0, R2 junk bits ignored
    wr(2, 16'h0000);
    wr(1, 16'hFD00);
    wr(0, 16'hABF0);
    pix_chk("R3", 10, 128, 128, {8'd0, 8'd0, 8'd0});
    pix_chk("R3", 200, 128, 128, {8'd184, 8'd184, 8'd184});

    // R7 back-to-back stream, identity gain, offset 0
    wr(0, 16'h0000);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k >= 3) check("R7", {out_valid, out_r, out_g, out_b},
                        {1'b1, 8'(10*(k-3)+5), 8'(10*(k-3)+5), 8'(10*(k-3)+5)});
      in_valid = (k < 4);
      in_y = 8'(10*k + 5); in_u = 8'd128; in_v = 8'd128;
    end
    in_valid = 1'b0;
    // R8 hold after stream
    @(negedge clk);
    @(negedge clk);
    check("R8", {out_valid, out_r, out_g, out_b}, {1'b0, 8'd35, 8'd35, 8'd35});

    // R9 write coincident with accepted pixel
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'd100; in_u = 8'd228; in_v = 8'd128;
    coef_we = 1'b1; coef_sel = 3'd6; coef_wdata = 16'h0100;
    @(negedge clk);
    coef_we = 1'b0;
    in_y = 8'd100; in_u = 8'd228; in_v = 8'd128;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    e0 = {8'd100, 8'd100, 8'd100};
    e1 = {8'd100, 8'd100, 8'd200};
    check("R9 old", {out_valid, out_r, out_g, out_b}, {1'b1, e0});
    @(negedge clk);
    check("R9 new", {out_valid, out_r, out_g, out_b}, {1'b1, e1});

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule